// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block stores the programmable priorities of the 64 local interrupt numbers for three privilege contexts: machine, supervisor and virtual supervisor. Each context has its own bank of 64 eight-bit entries. A lower value means a more urgent interrupt. The whole contents of all three banks are driven out in parallel so that a priority selector elsewhere can compare the pending interrupts in the same cycle.

Software-facing logic reaches the banks through a single access port. A 2-bit bank code selects the bank, a 6-bit index selects the entry, and a write strobe with write data completes the access. The machine and supervisor banks are addressed directly by interrupt number. The virtual bank is reachable only through a compact 16-slot view. In that view each slot stands for one chosen interrupt number, and three of the slots are tied to zero. At reset, every bank is loaded with a fixed urgency ordering, and each bank has its own exceptions to that ordering.

Top module: `irqPrioBank`

## Requirements
- R1: After reset, machine-bank entry n holds the default priority of n (R3), except entry 11, which holds 0.
- R2: After reset, supervisor-bank entry n holds the default priority of n (R3), except entry 9, which holds 0.
- R3: Default priority is a rank from most urgent (1) downward. For k = 0..3, the numbers 63-4k, 62-4k, 31-2k, 30-2k, 61-4k, 60-4k take ranks 1..24 in that order. Then 11, 3, 7, 9, 1, 5, 12, 10, 2, 6 take ranks 25..34. Then, for k = 0..3, the numbers 47-4k, 46-4k, 23-2k, 22-2k, 45-4k, 44-4k take ranks 35..58. Numbers 0, 4, 8, 13, 14 and 15 get the maximum value 255.
- R4: After reset, each virtual-bank entry reached by a writable slot holds the machine-bank reset value of that interrupt number. Every other virtual entry holds 0.
- R5: In the virtual view (bank code 2), slot s = 0..15 maps to interrupt numbers 0, 1, 4, 5, 8, 13, 14, 15, 16, 18, 20, 22, 24, 26, 28, 30 in that order.
- R6: Slots 0, 2 and 4 read as 0, and writes to them change nothing.
- R7: A virtual-view index of 16 to 63 reads as 0, and a write to it changes no entry.
- R8: Bank code 0 addresses the machine bank and bank code 1 the supervisor bank, by interrupt number. A write is visible on the outputs from the next rising clock edge. Reads are combinational from the stored value.
- R9: Bank code 3 reads as 0, and writes to it change nothing.
- R10: Virtual-bank entries not reached by any writable slot stay 0 on the parallel output at all times.
- R11: A write changes only the addressed entry of the addressed bank. With the write strobe low, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low; loads default contents |
| wrEn | input | 1 | Write strobe for the current access |
| accBank | input | 2 | Bank code: 0 machine, 1 supervisor, 2 virtual slot view, 3 none |
| accIndex | input | 6 | Interrupt number (codes 0, 1) or slot number (code 2) |
| wrData | input | 8 | Priority value to write |
| rdData | output | 8 | Combinational read of the addressed entry |
| machPrio | output | 512 | Machine bank, entry n at bits 8n+7..8n |
| supPrio | output | 512 | Supervisor bank, entry n at bits 8n+7..8n |
| virtPrio | output | 512 | Virtual bank, entry n at bits 8n+7..8n |

## Verification
The hardest case to reach is an access through the virtual view that must leave every entry unchanged: a write to a tied-zero slot, or to a slot index beyond 15. From the ports it looks the same as a write that worked. The stimulus first writes a marker value through valid slots. It then writes a different value through the tied-zero slots, through out-of-range indices and through bank code 3. After each of these writes it compares all 192 parallel outputs against a model. This shows that neither the mapped entries nor the hidden entries behind the tied-zero slots moved. The reset contents are checked entry by entry against a ranking list built in the bench from the stated ordering.

// File: rtl/irqPrioPkg.sv
package irqPrioPkg;

  localparam int NUM_IRQ      = 64;
  localparam int NUM_SLOT     = 16;
  localparam int IDX_W        = $clog2(NUM_IRQ);
  localparam int SLOT_W       = $clog2(NUM_SLOT);
  localparam int MACH_EXT_IRQ = 11;
  localparam int SUP_EXT_IRQ  = 9;

  typedef enum logic [1:0] {
    BANK_MACH  = 2'd0,
    BANK_SUP   = 2'd1,
    BANK_VSLOT = 2'd2,
    BANK_NONE  = 2'd3
  } bank_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             wrMach;
    logic             wrSup;
    logic             wrVirt;
    logic [IDX_W-1:0] entry;
    logic             rdZero;
    bank_e            rdBank;
  } accStrobe_t;

  // Position inside a six-entry group of the outer ordering bands.
  // d counts down from the top of the wide range, e from the narrow range.
  function automatic int widePos(int d);
    int j;
    j = d % 4;
    return 6 * (d / 4) + ((j < 2) ? j : j + 2);
  endfunction

  function automatic int narrowPos(int e);
    return 6 * (e / 2) + 2 + (e % 2);
  endfunction

  // Power-on urgency rank; lower is more urgent
  function automatic int defaultPrio(int irq, int maxPrio);
    int r;
    r = maxPrio;
    if (irq >= 48 && irq <= 63)      r = 1 + widePos(63 - irq);
    else if (irq >= 32)              r = 35 + widePos(47 - irq);
    else if (irq >= 24)              r = 1 + narrowPos(31 - irq);
    else if (irq >= 16)              r = 35 + narrowPos(23 - irq);
    else begin
      case (irq)
        11: r = 25;
        3:  r = 26;
        7:  r = 27;
        9:  r = 28;
        1:  r = 29;
        5:  r = 30;
        12: r = 31;
        10: r = 32;
        2:  r = 33;
        6:  r = 34;
        default: r = maxPrio;
      endcase
    end
    return r;
  endfunction

  // Virtual view: slot number to interrupt number
  function automatic int slotIrq(int s);
    int r;
    if (s <= 4)      r = 2 * s - (s % 2);
    else if (s <= 8) r = s + 8;
    else             r = 2 * s;
    return r;
  endfunction

  function automatic bit slotRdZero(int s);
    return (s == 0) || (s == 2) || (s == 4);
  endfunction

  function automatic bit isVirtMapped(int irq);
    bit hit;
    hit = 1'b0;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (slotIrq(s) == irq && !slotRdZero(s)) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/irqPrioCtrl.sv
module irqPrioCtrl
  import irqPrioPkg::*;
(
  input  logic                      wrEn,
  input  logic [1:0]                accBank,
  input  logic [IDX_W-1:0]          accIndex,
  output accStrobe_t                strobe
);

  logic slotOk;
  int   slotNum;

  assign slotOk  = (accIndex < IDX_W'(NUM_SLOT));
  assign slotNum = int'(accIndex[SLOT_W-1:0]);

  always_comb begin
    strobe        = '0;
    strobe.rdBank = bank_e'(accBank);
    strobe.entry  = accIndex;
    case (bank_e'(accBank))
      BANK_MACH: strobe.wrMach = wrEn;
      BANK_SUP:  strobe.wrSup  = wrEn;
      BANK_VSLOT: begin
        strobe.entry  = IDX_W'(slotIrq(slotNum));
        strobe.rdZero = !slotOk || slotRdZero(slotNum);
        strobe.wrVirt = wrEn && slotOk && !slotRdZero(slotNum);
      end
      default: strobe.rdZero = 1'b1;
    endcase
  end

endmodule

// File: rtl/irqPrioDatapath.sv
module irqPrioDatapath
  import irqPrioPkg::*;
#(
  parameter int PRIO_W   = 8,
  parameter int MAX_PRIO = 255
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  accStrobe_t                  strobe,
  input  logic [PRIO_W-1:0]           wrData,
  output logic [PRIO_W-1:0]           rdData,
  output logic [NUM_IRQ*PRIO_W-1:0]   machFlat,
  output logic [NUM_IRQ*PRIO_W-1:0]   supFlat,
  output logic [NUM_IRQ*PRIO_W-1:0]   virtFlat
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : gEntry
    localparam logic [PRIO_W-1:0] DEF_VAL  = PRIO_W'(defaultPrio(i, MAX_PRIO));
    localparam logic [PRIO_W-1:0] MACH_RST = (i == MACH_EXT_IRQ) ? '0 : DEF_VAL;
    localparam logic [PRIO_W-1:0] SUP_RST  = (i == SUP_EXT_IRQ)  ? '0 : DEF_VAL;

    logic hitEntry;
    logic [PRIO_W-1:0] machQ;
    logic [PRIO_W-1:0] supQ;

    assign hitEntry = (strobe.entry == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        machQ <= MACH_RST;
      else if (strobe.wrMach && hitEntry) machQ <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       supQ <= SUP_RST;
      else if (strobe.wrSup && hitEntry) supQ <= wrData;
    end

    assign machFlat[i*PRIO_W +: PRIO_W] = machQ;
    assign supFlat[i*PRIO_W +: PRIO_W]  = supQ;

    if (isVirtMapped(i)) begin : gVirt
      logic [PRIO_W-1:0] virtQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        virtQ <= MACH_RST;
        else if (strobe.wrVirt && hitEntry) virtQ <= wrData;
      end
      assign virtFlat[i*PRIO_W +: PRIO_W] = virtQ;
    end else begin : gTied
      assign virtFlat[i*PRIO_W +: PRIO_W] = '0;
    end
  end

  always_comb begin
    rdData = '0;
    if (!strobe.rdZero) begin
      case (strobe.rdBank)
        BANK_MACH:  rdData = machFlat[strobe.entry*PRIO_W +: PRIO_W];
        BANK_SUP:   rdData = supFlat[strobe.entry*PRIO_W +: PRIO_W];
        BANK_VSLOT: rdData = virtFlat[strobe.entry*PRIO_W +: PRIO_W];
        default:    rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/irqPrioBank.sv
module irqPrioBank
  import irqPrioPkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [1:0]                accBank,
  input  logic [IDX_W-1:0]          accIndex,
  input  logic [PRIO_W-1:0]         wrData,
  output logic [PRIO_W-1:0]         rdData,
  output logic [NUM_IRQ*PRIO_W-1:0] machPrio,
  output logic [NUM_IRQ*PRIO_W-1:0] supPrio,
  output logic [NUM_IRQ*PRIO_W-1:0] virtPrio
);

  localparam int MAX_PRIO = (1 << PRIO_W) - 1;

  accStrobe_t strobe;

  irqPrioCtrl u_ctrl (
    .wrEn     (wrEn),
    .accBank  (accBank),
    .accIndex (accIndex),
    .strobe   (strobe)
  );

  irqPrioDatapath #(
    .PRIO_W   (PRIO_W),
    .MAX_PRIO (MAX_PRIO)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdData   (rdData),
    .machFlat (machPrio),
    .supFlat  (supPrio),
    .virtFlat (virtPrio)
  );

endmodule

// File: rtl/irqPrioBankChk.sv
module irqPrioBankChk
  import irqPrioPkg::*;
#(
  parameter int PRIO_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [1:0]                accBank,
  input logic [IDX_W-1:0]          accIndex,
  input logic [PRIO_W-1:0]         wrData,
  input logic [PRIO_W-1:0]         rdData,
  input logic [NUM_IRQ*PRIO_W-1:0] machPrio,
  input logic [NUM_IRQ*PRIO_W-1:0] supPrio,
  input logic [NUM_IRQ*PRIO_W-1:0] virtPrio
);

  logic badSlot;
  logic zeroSlot;
  assign badSlot  = (accBank == 2'd2) && (accIndex >= IDX_W'(NUM_SLOT));
  assign zeroSlot = (accBank == 2'd2) &&
                    (accIndex == 6'd0 || accIndex == 6'd2 || accIndex == 6'd4);

  assert_mach_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accBank == 2'd0) |=>
      machPrio[$past(accIndex)*PRIO_W +: PRIO_W] == $past(wrData));

  assert_sup_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accBank == 2'd1) |=>
      supPrio[$past(accIndex)*PRIO_W +: PRIO_W] == $past(wrData));

  assert_mach_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accBank == 2'd0) |-> rdData == machPrio[accIndex*PRIO_W +: PRIO_W]);

  assert_zero_slot_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    zeroSlot |-> rdData == '0);

  assert_zero_slot_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (zeroSlot && wrEn) |=> $stable(virtPrio) && $stable(machPrio) && $stable(supPrio));

  assert_bad_slot_R7: assert property (@(posedge clk) disable iff (!rstN)
    (badSlot && wrEn) |=> $stable(virtPrio) && $stable(machPrio) && $stable(supPrio));

  assert_bad_slot_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    badSlot |-> rdData == '0);

  assert_no_bank_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accBank == 2'd3) |-> rdData == '0);

  assert_no_bank_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accBank == 2'd3 && wrEn) |=> $stable(virtPrio) && $stable(machPrio) && $stable(supPrio));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(virtPrio) && $stable(machPrio) && $stable(supPrio));

  assert_sup_untouched_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && accBank == 2'd0) |=> $stable(supPrio) && $stable(virtPrio));

endmodule

bind irqPrioBank irqPrioBankChk #(.PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/irqPrioBank_tb.sv
module irqPrioBank_tb;

  localparam int N = 64;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] accBank = 2'd0;
  logic [5:0] accIndex = 6'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic [N*W-1:0] machPrio, supPrio, virtPrio;

  always #10 clk = ~clk;

  irqPrioBank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .accBank(accBank), .accIndex(accIndex),
    .wrData(wrData), .rdData(rdData), .machPrio(machPrio), .supPrio(supPrio),
    .virtPrio(virtPrio)
  );

  typedef struct {
    int src;
    int idx;
    logic [W-1:0] exp;
    string tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  int defP[N];
  int mM[N], mS[N], mV[N];
  int slotMap[16] = '{0, 1, 4, 5, 8, 13, 14, 15, 16, 18, 20, 22, 24, 26, 28, 30};

  function automatic bit zeroSlot(int s);
    return s == 0 || s == 2 || s == 4;
  endfunction

  // Monitor: pops expected items in the low phase, away from edges
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sbq.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = sbq.pop_front();
        case (it.src)
          0: act = rdData;
          1: act = machPrio[it.idx*W +: W];
          2: act = supPrio[it.idx*W +: W];
          default: act = virtPrio[it.idx*W +: W];
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s src=%0d idx=%0d actual=%0d expected=%0d",
                   it.tag, it.src, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic expectOut(int src, int idx, int e, string tag);
    item_t it;
    it.src = src; it.idx = idx; it.exp = W'(e); it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic sweep(string tag);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      expectOut(1, i, mM[i], tag);
      expectOut(2, i, mS[i], tag);
      expectOut(3, i, mV[i], tag);
    end
  endtask

  task automatic readExp(int bank, int idx, int e, string tag);
    @(negedge clk);
    wrEn = 1'b0; accBank = 2'(bank); accIndex = 6'(idx);
    expectOut(0, idx, e, tag);
  endtask

  task automatic writeAcc(int bank, int idx, int d);
    @(negedge clk);
    accBank = 2'(bank); accIndex = 6'(idx); wrData = W'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    case (bank)
      0: mM[idx] = d;
      1: mS[idx] = d;
      2: if (idx < 16 && !zeroSlot(idx)) mV[slotMap[idx]] = d;
      default: ;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int order[$];
    int mid[10] = '{11, 3, 7, 9, 1, 5, 12, 10, 2, 6};
    for (int k = 0; k < 4; k++) begin
      order.push_back(63-4*k); order.push_back(62-4*k); order.push_back(31-2*k);
      order.push_back(30-2*k); order.push_back(61-4*k); order.push_back(60-4*k);
    end
    foreach (mid[m]) order.push_back(mid[m]);
    for (int k = 0; k < 4; k++) begin
      order.push_back(47-4*k); order.push_back(46-4*k); order.push_back(23-2*k);
      order.push_back(22-2*k); order.push_back(45-4*k); order.push_back(44-4*k);
    end
    for (int i = 0; i < N; i++) defP[i] = 255;
    foreach (order[n]) defP[order[n]] = n + 1;
    for (int i = 0; i < N; i++) begin
      mM[i] = (i == 11) ? 0 : defP[i];
      mS[i] = (i == 9) ? 0 : defP[i];
      mV[i] = 0;
    end
    for (int s = 0; s < 16; s++)
      if (!zeroSlot(s)) mV[slotMap[s]] = mM[slotMap[s]];

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R3 R4 R10: reset contents of all three banks
    sweep("R1_R2_R3_R4_R10_reset");
    readExp(0, 11, 0, "R1");
    readExp(0, 63, 1, "R3");
    readExp(0, 32, 58, "R3");
    readExp(0, 13, 255, "R3");
    readExp(1, 9, 0, "R2");
    readExp(1, 11, 25, "R2");
    readExp(2, 15, 4, "R4");
    readExp(2, 9, 50, "R4");

    // R8: direct writes, boundaries of the index range
    writeAcc(0, 11, 8'h42);
    readExp(0, 11, 8'h42, "R8");
    writeAcc(0, 0, 8'h07);
    writeAcc(0, 63, 8'hFE);
    writeAcc(1, 9, 8'h13);
    readExp(1, 9, 8'h13, "R8");
    readExp(0, 63, 8'hFE, "R8");
    sweep("R11_direct");

    // R5: virtual slot view
    writeAcc(2, 1, 8'hA1);
    writeAcc(2, 9, 8'hA9);
    writeAcc(2, 15, 8'hAF);
    writeAcc(2, 5, 8'hA5);
    readExp(2, 9, 8'hA9, "R5");
    readExp(2, 15, 8'hAF, "R5");
    sweep("R5_slots");

    // R6: tied-zero slots
    writeAcc(2, 0, 8'h55);
    writeAcc(2, 2, 8'h66);
    writeAcc(2, 4, 8'h77);
    readExp(2, 2, 0, "R6");
    readExp(2, 4, 0, "R6");
    sweep("R6_R10_zero_slots");

    // R7: slot index out of range
    writeAcc(2, 16, 8'h99);
    writeAcc(2, 63, 8'h98);
    readExp(2, 16, 0, "R7");
    readExp(2, 40, 0, "R7");
    sweep("R7_bad_slot");

    // R9: unused bank code
    writeAcc(3, 5, 8'h31);
    writeAcc(3, 11, 8'h32);
    readExp(3, 5, 0, "R9");
    sweep("R9_no_bank");

    // R11: write strobe low leaves everything as it was
    @(negedge clk);
    accBank = 2'd0; accIndex = 6'd20; wrData = 8'h01; wrEn = 1'b0;
    repeat (3) @(negedge clk);
    sweep("R11_idle");

    repeat (2) @(negedge clk);
    #10;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule